// File: doc/BRIEF.md
# Command Queue Aging Arbiter

This block is the front-end command store of a memory controller. Read and write transactions enter through a valid/ready push port. Each one carries a transaction ID, a read/write flag, a target chip select and an address. Every transaction is held in one of a fixed number of slots. From the cycle it is written, each slot counts down a private starvation timer. The value loaded into that timer depends on the transaction ID and on a fast-request input sampled at push time.

A single issue port presents the next command to the downstream scheduler, which takes it with a pop handshake. Any entry whose timer has run out goes ahead of all entries that still have time left. Within a group, the entry that arrived first goes first. Two flags tell the scheduler whether any queued work targets chip 0 or chip 1.

Timeouts and QoS settings are written through a small register-write port. Reset makes them usable without any writes: the default timeout is all ones, the QoS ID is zero, both QoS counts are all ones, and adaptive selection is off.

Top module: `cmdq_aging_arb`

## Requirements
- R1: An entry written with reload value T shows as expired exactly T clock cycles after the edge that wrote it. The default reload, used when the ID does not match, resets to 0xFFF.
- R2: A pushed transaction whose ID equals the configured QoS ID loads the normal QoS count instead of the default timeout, provided the fast count is not selected.
- R3: The fast QoS count is loaded only when adaptive mode is enabled, the ID matches and `fast_req` is high at push. Adaptive mode resets to disabled, and while it is disabled `fast_req` has no effect.
- R4: While any queued entry has expired, the presented command is an expired one and `pop_expired` is 1, regardless of how many older entries have not expired.
- R5: Among expired entries the oldest is presented. When none has expired, the oldest entry overall is presented.
- R6: A timer stops at zero. An expired entry stays expired until it is popped.
- R7: The queue holds DEPTH (default 8) entries. `full` is 1 and `push_ready` is 0 when all slots are occupied. A push offered while full is dropped and never appears at the issue port.
- R8: A pop frees the presented entry's slot on that same edge. From the next cycle the entry is no longer presented, and `pop_valid` is 0 once the queue is empty.
- R9: `chip0_empty` (`chip1_empty`) is 1 exactly when no queued entry has `chip` = 0 (1). Both read 1 after reset.
- R10: Register writes take effect on the edge where `cfg_we` is 1. The write address selects the register: address 0 holds the default timeout in bits [11:0] and the adaptive enable in bit 12; address 1 holds the QoS ID in bits [ID_W-1:0]; address 2 holds the normal QoS count; address 3 holds the fast QoS count. Counts occupy bits [11:0].
- R11: After reset the queue is empty: `pop_valid` is 0, `full` is 0 and `push_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Transaction offered |
| push_ready | output | 1 | A free slot exists |
| push_id | input | ID_W | Transaction ID |
| push_write | input | 1 | 1 = write, 0 = read |
| push_chip | input | 1 | Target chip select |
| push_addr | input | ADDR_W | Transaction address |
| fast_req | input | 1 | Fast QoS request, sampled with the push |
| pop_valid | output | 1 | A command is presented |
| pop_ready | input | 1 | Scheduler takes the presented command |
| pop_id | output | ID_W | ID of the presented command |
| pop_write | output | 1 | Direction of the presented command |
| pop_chip | output | 1 | Chip of the presented command |
| pop_addr | output | ADDR_W | Address of the presented command |
| pop_expired | output | 1 | Presented command has timed out |
| full | output | 1 | All slots occupied |
| chip0_empty | output | 1 | No queued entry targets chip 0 |
| chip1_empty | output | 1 | No queued entry targets chip 1 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |

## Verification
The bench uses the default parameters: DEPTH = 8, 12-bit counts, a 4-bit ID and 16-bit addresses. The 8-slot depth lets it fill the queue in a few dozen cycles and probe the full and dropped-push cases. The 12-bit count lets one run wait out the reset default of 4095 cycles. Programming small reloads through the register port makes the expiry timing and every reload-source combination observable within tens of cycles. This also allows orderings where a young expired entry overtakes older live entries.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  typedef enum logic [1:0] {
    REG_TIMEOUT  = 2'd0,
    REG_QOS_ID   = 2'd1,
    REG_QOS_CNT  = 2'd2,
    REG_QOS_FAST = 2'd3
  } cfg_reg_e;

  localparam int ADAPT_BIT = 12;

endpackage

// File: rtl/cmdq_cfg_regs.sv
module cmdq_cfg_regs
  import cmdq_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int CNT_W = 12,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [ID_W-1:0]  req_id,
  input  logic             req_fast,
  output logic [CNT_W-1:0] reload
);

  logic [CNT_W-1:0] dflt_q, qos_q, fast_q;
  logic [ID_W-1:0]  qid_q;
  logic             adapt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dflt_q  <= '1;
      qos_q   <= '1;
      fast_q  <= '1;
      qid_q   <= '0;
      adapt_q <= 1'b0;
    end else if (cfg_we) begin
      unique case (cfg_reg_e'(cfg_addr))
        REG_TIMEOUT: begin
          dflt_q  <= cfg_wdata[CNT_W-1:0];
          adapt_q <= cfg_wdata[ADAPT_BIT];
        end
        REG_QOS_ID:   qid_q  <= cfg_wdata[ID_W-1:0];
        REG_QOS_CNT:  qos_q  <= cfg_wdata[CNT_W-1:0];
        REG_QOS_FAST: fast_q <= cfg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    if (req_id != qid_q)          reload = dflt_q;
    else if (adapt_q && req_fast) reload = fast_q;
    else                          reload = qos_q;
  end

  assert_cfg_timeout_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd0) |=> (dflt_q == $past(cfg_wdata[CNT_W-1:0])));

  assert_cfg_adapt_R3: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we || cfg_addr != 2'd0) |=> (adapt_q == $past(adapt_q)));

endmodule

// File: rtl/cmdq_slot.sv
module cmdq_slot #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              clr,
  input  logic [ID_W-1:0]   in_id,
  input  logic              in_write,
  input  logic              in_chip,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CNT_W-1:0]  in_cnt,
  output logic              valid_o,
  output logic [ID_W-1:0]   id_o,
  output logic              write_o,
  output logic              chip_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              expired_o
);

  logic             valid_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      cnt_q   <= in_cnt;
    end else if (valid_q && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // payload carries no reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (load) begin
      id_o    <= in_id;
      write_o <= in_write;
      chip_o  <= in_chip;
      addr_o  <= in_addr;
    end
  end

  assign valid_o   = valid_q;
  assign expired_o = valid_q && (cnt_q == '0);

  assert_expired_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (expired_o && !clr) |=> expired_o);

  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !clr && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/cmdq_age_pick.sv
module cmdq_age_pick #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] push_oh,
  input  logic [DEPTH-1:0] valid,
  input  logic [DEPTH-1:0] expired,
  output logic [DEPTH-1:0] grant
);

  // older_q[i][j] = 1 when slot i was written before slot j
  logic [DEPTH-1:0] older_q [DEPTH];
  logic [DEPTH-1:0] cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) older_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_oh[i]) older_q[i] <= '0;
        else begin
          for (int j = 0; j < DEPTH; j++)
            if (push_oh[j]) older_q[i][j] <= 1'b1;
        end
      end
    end
  end

  assign cand = (|expired) ? expired : valid;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_pick
      logic [DEPTH-1:0] self_m;
      assign self_m   = DEPTH'(1) << i;
      assign grant[i] = cand[i] && (&(~cand | older_q[i] | self_m));
    end
  endgenerate

  assert_grant_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_grant_present_R5: assert property (@(posedge clk) disable iff (rst)
    (|valid) |-> (|grant));

  always @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < DEPTH; i++)
        for (int j = 0; j < DEPTH; j++)
          if (i != j && valid[i] && valid[j])
            assert_age_order_R5: assert (older_q[i][j] != older_q[j][i]);
    end
  end

endmodule

// File: rtl/cmdq_aging_arb.sv
module cmdq_aging_arb #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 12,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_valid,
  output logic              push_ready,
  input  logic [ID_W-1:0]   push_id,
  input  logic              push_write,
  input  logic              push_chip,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              fast_req,
  output logic              pop_valid,
  input  logic              pop_ready,
  output logic [ID_W-1:0]   pop_id,
  output logic              pop_write,
  output logic              pop_chip,
  output logic [ADDR_W-1:0] pop_addr,
  output logic              pop_expired,
  output logic              full,
  output logic              chip0_empty,
  output logic              chip1_empty,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata
);

  logic [CNT_W-1:0]  reload;
  logic [DEPTH-1:0]  valid_v, exp_v, chip_v, write_v, free_v, push_oh, grant, load_v, clr_v;
  logic [ID_W-1:0]   id_a   [DEPTH];
  logic [ADDR_W-1:0] addr_a [DEPTH];
  logic              push_fire, pop_fire;

  cmdq_cfg_regs #(.ID_W(ID_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) i_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_id(push_id), .req_fast(fast_req), .reload(reload)
  );

  assign free_v    = ~valid_v;
  assign push_oh   = free_v & (~free_v + 1'b1);
  assign push_fire = push_valid && (|free_v);
  assign load_v    = push_fire ? push_oh : '0;
  assign pop_fire  = pop_valid && pop_ready;
  assign clr_v     = pop_fire ? grant : '0;

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
      cmdq_slot #(.ID_W(ID_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_slot (
        .clk(clk), .rst(rst), .load(load_v[k]), .clr(clr_v[k]),
        .in_id(push_id), .in_write(push_write), .in_chip(push_chip),
        .in_addr(push_addr), .in_cnt(reload),
        .valid_o(valid_v[k]), .id_o(id_a[k]), .write_o(write_v[k]),
        .chip_o(chip_v[k]), .addr_o(addr_a[k]), .expired_o(exp_v[k])
      );
    end
  endgenerate

  cmdq_age_pick #(.DEPTH(DEPTH)) i_pick (
    .clk(clk), .rst(rst), .push_oh(load_v), .valid(valid_v),
    .expired(exp_v), .grant(grant)
  );

  always_comb begin
    pop_id      = '0;
    pop_addr    = '0;
    pop_write   = 1'b0;
    pop_chip    = 1'b0;
    pop_expired = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (grant[k]) begin
        pop_id      = pop_id | id_a[k];
        pop_addr    = pop_addr | addr_a[k];
        pop_write   = pop_write | write_v[k];
        pop_chip    = pop_chip | chip_v[k];
        pop_expired = pop_expired | exp_v[k];
      end
    end
  end

  assign pop_valid   = |valid_v;
  assign full        = &valid_v;
  assign push_ready  = ~full;
  assign chip0_empty = ~|(valid_v & ~chip_v);
  assign chip1_empty = ~|(valid_v & chip_v);

  assert_expired_first_R4: assert property (@(posedge clk) disable iff (rst)
    (|exp_v) |-> pop_expired);

  assert_pop_frees_R8: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && !push_fire) |=> ($countones(valid_v) == $past($countones(valid_v)) - 1));

  assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (full && !pop_fire) |=> full);

  assert_chip_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (pop_valid && !pop_chip) |-> !chip0_empty);

endmodule

// File: tb/test_cmdq_aging_arb.sv
module test_cmdq_aging_arb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push_valid = 0, push_write = 0, push_chip = 0, fast_req = 0;
  logic [3:0]  push_id = 0;
  logic [15:0] push_addr = 0;
  logic        pop_ready = 0, cfg_we = 0;
  logic [1:0]  cfg_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic        push_ready, pop_valid, pop_write, pop_chip, pop_expired, full;
  logic        chip0_empty, chip1_empty;
  logic [3:0]  pop_id;
  logic [15:0] pop_addr;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  cmdq_aging_arb i_cmdq_aging_arb (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_ready(push_ready),
    .push_id(push_id), .push_write(push_write), .push_chip(push_chip),
    .push_addr(push_addr), .fast_req(fast_req), .pop_valid(pop_valid),
    .pop_ready(pop_ready), .pop_id(pop_id), .pop_write(pop_write),
    .pop_chip(pop_chip), .pop_addr(pop_addr), .pop_expired(pop_expired),
    .full(full), .chip0_empty(chip0_empty), .chip1_empty(chip1_empty),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(int a, int d);
    @(negedge clk); cfg_we = 1; cfg_addr = a[1:0]; cfg_wdata = d[15:0];
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic push(int id, int chip, int fast);
    @(negedge clk); push_valid = 1; push_id = id[3:0]; push_chip = chip[0];
    push_write = id[0]; push_addr = 16'h100 + id[15:0]; fast_req = fast[0];
    @(negedge clk); push_valid = 0; fast_req = 0;
  endtask

  task automatic pop();
    pop_ready = 1;
    @(negedge clk); pop_ready = 0;
  endtask

  // edges elapsed from the write edge until pop_expired rises
  task automatic measure(output int k);
    k = 0;
    while (!pop_expired && k < 5000) begin
      @(negedge clk); k++;
    end
  endtask

  localparam int NV = 5;
  localparam int V_ID  [NV] = '{2, 2, 9, 9, 9};
  localparam int V_FST [NV] = '{0, 1, 0, 1, 1};
  localparam int V_ADP [NV] = '{0, 1, 1, 0, 1};
  localparam int V_EXP [NV] = '{5, 5, 3, 3, 1};
  localparam string V_REQ [NV] = '{"R1", "R2", "R2", "R3", "R3"};

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 / R9 reset state
    check("R11 pop_valid", pop_valid, 0);
    check("R11 full", full, 0);
    check("R11 push_ready", push_ready, 1);
    check("R9 chip0_empty", chip0_empty, 1);
    check("R9 chip1_empty", chip1_empty, 1);

    // R1 reset default timeout 0xFFF
    push(1, 0, 0);
    measure(k);
    check("R1 default 0xFFF", k, 4095);
    pop();

    // R10 programming, then R2/R3 reload-source table
    cfg(1, 9); cfg(2, 3); cfg(3, 1);
    for (int v = 0; v < NV; v++) begin
      cfg(0, (V_ADP[v] << 12) | 5);
      push(V_ID[v], 0, V_FST[v]);
      measure(k);
      check({V_REQ[v], " reload"}, k, V_EXP[v]);
      check({V_REQ[v], " id"}, pop_id, V_ID[v]);
      pop();
    end
    check("R8 empty after pops", pop_valid, 0);

    // R4 / R5 / R9: young expired entry overtakes older live ones
    cfg(0, 40); cfg(2, 2);
    push(1, 0, 0);
    push(2, 1, 0);
    check("R9 chip0 busy", chip0_empty, 0);
    check("R9 chip1 busy", chip1_empty, 0);
    check("R5 oldest first", pop_id, 1);
    push(9, 1, 0);
    @(negedge clk); @(negedge clk);
    check("R4 expired flag", pop_expired, 1);
    check("R4 expired first", pop_id, 9);
    pop();
    check("R5 oldest live", pop_id, 1);
    check("R5 live not expired", pop_expired, 0);
    pop();
    check("R8 next", pop_id, 2);
    check("R9 chip0 freed", chip0_empty, 1);
    check("R9 chip1 held", chip1_empty, 0);
    pop();
    check("R8 drained", pop_valid, 0);
    check("R9 chip1 freed", chip1_empty, 1);

    // R5 / R6: several expired, oldest expired wins; expiry persists
    cfg(0, 3);
    push(3, 0, 0);
    push(4, 0, 0);
    cfg(0, 30);
    push(5, 0, 0);
    repeat (20) @(negedge clk);
    check("R6 still expired", pop_expired, 1);
    check("R5 oldest expired", pop_id, 3);
    pop();
    check("R5 second expired", pop_id, 4);
    check("R6 second expired", pop_expired, 1);
    pop();
    check("R5 live last", pop_id, 5);
    pop();

    // R7 fill, dropped push, drain order
    cfg(0, 4000);
    for (int i = 0; i < 8; i++) push(i, i % 2, 0);
    check("R7 full", full, 1);
    check("R7 push_ready", push_ready, 0);
    push(15, 0, 0);
    for (int i = 0; i < 8; i++) begin
      check("R7 drain id", pop_id, i);
      check("R7 drain addr", pop_addr, 16'h100 + i);
      pop();
    end
    check("R7 dropped push absent", pop_valid, 0);
    check("R7 not full", full, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule